// File: doc/BRIEF.md
# Planar Scanline Pixel Fetcher with Fine Horizontal Shift

This block turns one displayed row of a four-plane, 32-bit wide video memory into a stream of palette indexes. Each memory word holds one byte per plane. The word is read as eight planar pixels in 16-colour or 4-colour mode, or as four byte-wide pixels in 256-colour mode. Any mode can be pixel-doubled. A fine horizontal shift of a few pixels is applied by discarding leading pixels of the expanded row. Fetching simply continues into the following word, so the visible width always stays full.

A frame begins with `frame_start`, which loads the row address from `start_addr`. Each `line_start` accepted while idle produces exactly `groups*8` output pixels for the current row. It then moves the row address forward by the row stride when the row-repeat condition holds. When the line counter reaches `line_cmp`, the fetch address restarts at zero. If `pan_split` is set, the shift is also forced to zero from that line to the end of the frame. The output is a valid/ready stream that can be stalled for any number of cycles. Memory is read through a request port with a fixed latency of one cycle.

Top module: `planar_scan_fetch`

## Requirements
- R1: After reset, and whenever `busy` is low, `mem_req` and `pix_valid` are low.
- R2: The words of one line are requested at consecutive 16-bit word indexes, beginning at the line base. The index wraps from 0xFFFF to 0x0000.
- R3: `frame_start` sets the row address to `start_addr` and the line counter to 0. After line n is started, the row address becomes base + 2*`line_off` words if (n[1:0] & `row_rep`) == `row_rep`. Otherwise the row address becomes the base.
- R4: With `mode`=0 (16-colour), pixel k (k=0..7, leftmost first) of a word has bit p equal to bit 7-k of byte p of the word. The output bits 7:4 are zero.
- R5: With `mode`=1 (4-colour), pixels 0..3 use bytes 0 (low pair) and 2 (high pair), and pixels 4..7 use bytes 1 and 3. Pixel k mod 4 takes bits [7-2k:6-2k] of each byte. The index is {high pair, low pair}.
- R6: With `mode`=2 or 3 (256-colour), each word holds four pixels, byte 0 first, and each byte is the full 8-bit index.
- R7: In modes 0 and 1, byte p of every word is forced to zero when `plane_en[p]` is 0. In the 256-colour modes, `plane_en` has no effect.
- R8: The number of leading source pixels dropped is `pel[2:0]` in modes 0/1 and `pel[2:1]` in modes 2/3. Bit 3 of `pel` is ignored, so a value of 8 gives no shift.
- R9: With `dbl`=1, each source pixel is emitted twice. The drop count is applied in source pixels, so twice as many output pixels are removed.
- R10: A line emits exactly `groups*8` pixels. `busy` then falls, and no further pixel is offered.
- R11: On the line whose counter equals `line_cmp`, the base is 0. If `pan_split` is 1 on that line, the shift is zero on that line and on every later line until the next `frame_start`.
- R12: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and `pix` holds its value. No pixel is lost or repeated.
- R13: A `line_start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Restart the row address and the line counter |
| line_start | input | 1 | Begin one line (taken only when idle) |
| start_addr | input | 16 | Word index of the first row |
| line_off | input | 8 | Row stride in units of 8 bytes |
| line_cmp | input | 10 | Line at which the fetch address restarts at 0 |
| row_rep | input | 2 | Line-counter bits that must be all ones for the row to advance |
| pel | input | 4 | Fine horizontal shift value |
| pan_split | input | 1 | Force zero shift from the compare line onward |
| plane_en | input | 4 | Plane enable mask for the planar modes |
| mode | input | 2 | 0: 16-colour, 1: 4-colour, 2/3: 256-colour |
| dbl | input | 1 | Emit each pixel twice |
| groups | input | 8 | Line length in 8-pixel output groups (at least 1) |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory word index |
| mem_data | input | 32 | Read data, valid one cycle after `mem_req` |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix | output | 8 | Palette index |
| busy | output | 1 | A line is in progress |

## Verification
The bench sweeps every shift value, every mode and both doubling settings, using a varied plane mask. A fetcher that took the shift from the wrong bits, or skipped pixels in output units instead of source units, shows up at the first pixels of a line. A row that starts near the top of memory checks the address wrap: a fetcher without it reads beyond the 16-bit index space and returns the wrong words. Frames are run with the compare line inside the frame, with and without the split flag. A design that kept the shift below the split, or failed to restart the address at zero, emits pixels from the wrong row. A periodic ready stall and a `line_start` pulsed in the middle of a line show pixels that are dropped or repeated, and show any restart of the line.

// File: rtl/planar_scan_fetch.sv
module planar_scan_fetch #(
  parameter int AW = 16,
  parameter int LW = 10,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic [AW-1:0] start_addr,
  input  logic [7:0]    line_off,
  input  logic [LW-1:0] line_cmp,
  input  logic [1:0]    row_rep,
  input  logic [3:0]    pel,
  input  logic          pan_split,
  input  logic [3:0]    plane_en,
  input  logic [1:0]    mode,
  input  logic          dbl,
  input  logic [GW-1:0] groups,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_data,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [7:0]    pix,
  output logic          busy
);
  localparam int CW = GW + 3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_LOAD, S_EMIT} st_t;
  st_t st;

  logic [AW-1:0] row, cur;
  logic [LW-1:0] lnum;
  logic          split, first, half;
  logic [31:0]   wbuf;
  logic [2:0]    pi, skip_q;
  logic [1:0]    mode_q;
  logic          dbl_q;
  logic [3:0]    pe_q;
  logic [CW-1:0] ocnt, total;

  wire           hit   = (lnum == line_cmp);
  wire [AW-1:0]  base  = hit ? '0 : row;
  wire           spl   = split | (hit & pan_split);
  wire [2:0]     sk    = spl ? 3'd0 : (mode[1] ? {1'b0, pel[2:1]} : pel[2:0]);
  wire           adv   = ((lnum[1:0] & row_rep) == row_rep);
  wire [AW-1:0]  step  = AW'({line_off, 1'b0});
  wire           take  = (st == S_IDLE) && line_start && !frame_start;
  wire           hs    = (st == S_EMIT) && pix_ready;
  wire           wlast = mode_q[1] ? (pi[1:0] == 2'd3) : (pi == 3'd7);
  wire [31:0]    pmask = {{8{pe_q[3]}}, {8{pe_q[2]}}, {8{pe_q[1]}}, {8{pe_q[0]}}};

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_REQ);
  assign mem_addr  = cur;
  assign pix_valid = (st == S_EMIT);

  always_comb begin
    logic [7:0] lo, hi;
    int sh;
    pix = '0;
    lo  = pi[2] ? wbuf[15:8]  : wbuf[7:0];
    hi  = pi[2] ? wbuf[31:24] : wbuf[23:16];
    sh  = 6 - 2 * int'(pi[1:0]);
    case (mode_q)
      2'd0: for (int p = 0; p < 4; p++) pix[p] = wbuf[8*p + 7 - int'(pi)];
      2'd1: pix = {4'd0, hi[sh +: 2], lo[sh +: 2]};
      default: pix = wbuf[8*int'(pi[1:0]) +: 8];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; row <= '0; cur <= '0; lnum <= '0; split <= 1'b0;
      first <= 1'b0; half <= 1'b0; wbuf <= '0; pi <= '0; skip_q <= '0;
      mode_q <= '0; dbl_q <= 1'b0; pe_q <= '0; ocnt <= '0; total <= '0;
    end else begin
      if (frame_start) begin
        row <= start_addr; lnum <= '0; split <= 1'b0;
      end else if (take) begin
        row   <= base + (adv ? step : '0);
        lnum  <= lnum + 1'b1;
        split <= spl;
      end
      case (st)
        S_IDLE: if (take) begin
          cur <= base; skip_q <= sk; first <= 1'b1; half <= 1'b0; ocnt <= '0;
          mode_q <= mode; dbl_q <= dbl; pe_q <= plane_en;
          total <= CW'({groups, 3'b000}) - 1'b1;
          st <= S_REQ;
        end
        S_REQ: begin
          cur <= cur + 1'b1;
          st  <= S_LOAD;
        end
        S_LOAD: begin
          wbuf  <= mode_q[1] ? mem_data : (mem_data & pmask);
          pi    <= first ? skip_q : 3'd0;
          first <= 1'b0;
          st    <= S_EMIT;
        end
        S_EMIT: if (hs) begin
          ocnt <= ocnt + 1'b1;
          if (ocnt == total) st <= S_IDLE;
          else if (dbl_q && !half) half <= 1'b1;
          else begin
            half <= 1'b0;
            pi   <= pi + 1'b1;
            if (wlast) st <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module planar_scan_fetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic [15:0] mem_addr,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic [7:0]  pix,
  input logic [1:0]  mode
);
  logic        seen;
  logic [15:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; last <= '0;
    end else if (!busy) begin
      seen <= 1'b0;
    end else if (mem_req) begin
      seen <= 1'b1; last <= mem_addr;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !pix_valid));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_req && seen) |-> (mem_addr == 16'(last + 16'd1)));

  p_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !mode[1]) |-> (pix[7:4] == 4'd0));

  p_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pix_valid && pix_ready));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix)));
endmodule

bind planar_scan_fetch planar_scan_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
  .mem_addr(mem_addr), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix(pix), .mode(mode)
);

// File: tb/sim_planar_scan_fetch.sv
module sim_planar_scan_fetch;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, line_start = 0, pan_split = 0, dbl = 0, pix_ready = 0;
  logic [15:0] start_addr = 0, mem_addr;
  logic [7:0]  line_off = 0, groups = 2, pix;
  logic [9:0]  line_cmp = 10'd1023;
  logic [1:0]  row_rep = 0, mode = 0;
  logic [3:0]  pel = 0, plane_en = 4'hF;
  logic [31:0] mem_data = 0;
  logic        mem_req, pix_valid, busy;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] m_row = 0;
  int          m_line = 0;
  bit          m_split = 0;

  always #4 clk = ~clk;

  planar_scan_fetch u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .start_addr(start_addr), .line_off(line_off), .line_cmp(line_cmp),
    .row_rep(row_rep), .pel(pel), .pan_split(pan_split), .plane_en(plane_en),
    .mode(mode), .dbl(dbl), .groups(groups), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix(pix), .busy(busy)
  );

  function automatic logic [31:0] memf(input logic [15:0] a);
    logic [7:0] b0, b1, b2, b3;
    b0 = a[7:0] ^ 8'h3C;
    b1 = {a[3:0], a[7:4]} ^ a[15:8];
    b2 = ~a[7:0] + a[15:8];
    b3 = a[7:0] * 8'd11 + 8'd7;
    return {b3, b2, b1, b0};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) mem_data <= memf(mem_addr);
  end

  function automatic logic [7:0] exp_pix(input logic [15:0] base, input int skip,
      input int j, input logic [1:0] md, input logic db, input logic [3:0] pe);
    int src, ppw, pos, k;
    logic [31:0] w;
    logic [7:0] r, lo, hi;
    src = skip + (db ? j / 2 : j);
    ppw = md[1] ? 4 : 8;
    w = memf(base + 16'(src / ppw));
    pos = src % ppw;
    r = 0;
    if (md[1]) return w[8*pos +: 8];
    for (int p = 0; p < 4; p++) if (!pe[p]) w[8*p +: 8] = 8'h00;  // R7
    if (md == 2'd0) begin
      for (int p = 0; p < 4; p++) r[p] = w[8*p + 7 - pos];
    end else begin
      k  = pos % 4;
      lo = (pos >= 4) ? w[15:8]  : w[7:0];
      hi = (pos >= 4) ? w[31:24] : w[23:16];
      r  = {4'd0, hi[7-2*k], hi[6-2*k], lo[7-2*k], lo[6-2*k]};
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic new_frame();
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
    m_row = start_addr; m_line = 0; m_split = 0;
  endtask

  // model of R3, R8, R11, then one line with periodic stalls (R12)
  task automatic do_line(input bit poke);
    logic [15:0] base;
    int skip, n, t;
    bit hit;
    string tag;
    hit  = (m_line == int'(line_cmp));
    base = hit ? 16'd0 : m_row;
    m_split = m_split | (hit & pan_split);
    skip = m_split ? 0 : (mode[1] ? int'(pel[2:1]) : int'(pel[2:0]));
    m_row = base + ((((m_line % 4) & int'(row_rep)) == int'(row_rep)) ? 16'({line_off, 1'b0}) : 16'd0);
    m_line++;
    tag = (mode == 0) ? "R4" : (mode == 1) ? "R5" : "R6";
    @(negedge clk) line_start = 1;
    @(negedge clk) line_start = 0;
    n = 0; t = 0;
    while (n < int'(groups) * 8 && t < 4000) begin
      @(negedge clk);
      pix_ready = (cyc % 5) != 2;
      line_start = poke && (n == 5);  // R13
      if (pix_valid && pix_ready) begin
        chk(tag, pix, exp_pix(base, skip, n, mode, dbl, plane_en));
        n++;
      end
      t++;
    end
    line_start = 0;
    chk("R10", n, int'(groups) * 8);
    repeat (3) @(negedge clk);
    chk("R10", {busy, pix_valid}, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {busy, pix_valid, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {busy, pix_valid, mem_req}, 0);

    // R4 R5 R6 R7 R8 R9: all modes, doubling, all shift values
    for (int md = 0; md < 3; md++)
      for (int d = 0; d < 2; d++)
        for (int pv = 0; pv < 16; pv++) begin
          mode = 2'(md); dbl = d[0]; pel = 4'(pv);
          plane_en = 4'(pv ^ (md * 5) ^ (d * 9));
          start_addr = 16'(pv * 37 + md * 1000 + d * 333);
          groups = 2;
          new_frame();
          do_line(0);
        end

    // R3: row advance every second line, then every line
    mode = 0; dbl = 0; pel = 0; plane_en = 4'hF; line_off = 5;
    start_addr = 16'd100; row_rep = 2'd1;
    new_frame();
    for (int i = 0; i < 5; i++) do_line(0);
    row_rep = 2'd0;
    new_frame();
    for (int i = 0; i < 3; i++) do_line(0);

    // R11: compare line with and without split neutralisation
    for (int s = 0; s < 2; s++) begin
      pan_split = s[0]; line_cmp = 10'd2; pel = 4'd3; mode = 2'd1; line_off = 3;
      start_addr = 16'd500;
      new_frame();
      for (int i = 0; i < 5; i++) do_line(0);
    end
    pan_split = 0; line_cmp = 10'd1023;

    // R2: wrap past the top of memory
    mode = 2'd2; pel = 4'd6; groups = 4; start_addr = 16'hFFFE;
    new_frame();
    do_line(0);
    mode = 2'd0; pel = 4'd5; dbl = 1; start_addr = 16'hFFFF;
    new_frame();
    do_line(0);

    // R13: line_start pulsed mid-line is ignored
    dbl = 0; groups = 3; start_addr = 16'd40; line_off = 2;
    new_frame();
    do_line(1);
    do_line(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule